// File: doc/BRIEF.md
# Bidirectional Handshake Parallel Port

This block is an 8-bit parallel port that moves bytes in both directions between a CPU and a peripheral over one shared set of data pins. Two strobe/ready pairs carry the handshake. The output pair is an output-ready line driven by the port and an output strobe driven by the peripheral. The input pair is an input-ready line and an input strobe. The port drives the shared pins only while the peripheral holds the output strobe low. At every other time the pins are released. The pins are modelled as separate in, out and output-enable signals, so that an outer pad ring can build the tri-state buffer.

The CPU reaches the port through read, write, chip-enable, data/control select and I/O-request inputs. A data access is recognised on the first clock cycle of the AND of its four qualifying terms. A control write sets two interrupt enable bits. A single mode input turns bidirectional operation on or off. When a transfer in either direction completes, a pending flag is set. Each enabled pending flag raises a level interrupt request, which stays active until it is acknowledged. When both flags are pending, the input source is reported first.

All strobes and CPU inputs are assumed to be synchronous to `clk`.

Top module: `bidir_hs_port`

## Requirements
- R1: After a synchronous reset with mode high, the outputs are: out_rdy=0, in_rdy=1, pd_oe=0, irq=0, and both interrupt enables cleared.
- R2: A data write is the AND of cpu_wr, cpu_ce, cpu_dsel=1 and cpu_iorq. On the clock edge of its first cycle it loads cpu_wdata into the output latch and raises out_rdy. If any of the four terms is missing, out_rdy is unchanged.
- R3: pd_oe is 1 exactly while out_stb_n is low and mode is high. pd_out always presents the output latch.
- R4: When out_stb_n rises while out_rdy is high, out_rdy falls on that edge and the output pending flag is set.
- R5: If in_stb_n falls while in_rdy is high, pd_in is captured while the strobe stays low. On its rise, in_rdy falls and the input pending flag is set. A strobe that begins while in_rdy is low captures nothing and sets nothing.
- R6: cpu_rdata returns the input register only while cpu_rd, cpu_ce, cpu_dsel=1 and cpu_iorq are all high. A control read (cpu_dsel=0) returns {6'b0, input enable, output enable}. Otherwise cpu_rdata is 0.
- R7: After the first cycle of a data read, in_rdy is low for RDY_GAP (default 2) clock cycles and then returns high. This holds whether in_rdy was high or low before the read.
- R8: A control write with cpu_dsel=0 sets the output interrupt enable from cpu_wdata bit 0 and the input interrupt enable from bit 1. irq is high while any enabled pending flag is set.
- R9: When both enabled flags are pending, irq_src=1 (input). A pulse on irq_ack clears only the reported flag, after which irq_src=0 (output).
- R10: While mode is low, in_rdy, out_rdy and pd_oe stay 0, and data writes and strobes have no effect. The output latch and its ready state are kept for when mode returns high.
- R11: A data write in the same cycle as a completing output strobe rise loads the new byte, keeps out_rdy high, and still sets the output pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_bidir | input | 1 | Bidirectional mode enable |
| cpu_rd | input | 1 | CPU read |
| cpu_wr | input | 1 | CPU write |
| cpu_ce | input | 1 | Chip enable |
| cpu_dsel | input | 1 | 1 = data register, 0 = control register |
| cpu_iorq | input | 1 | I/O request |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| pd_in | input | 8 | Peripheral data pins, input side |
| pd_out | output | 8 | Peripheral data pins, output side |
| pd_oe | output | 1 | Pin output enable |
| out_stb_n | input | 1 | Output strobe from peripheral, active low |
| out_rdy | output | 1 | Output data ready |
| in_stb_n | input | 1 | Input strobe from peripheral, active low |
| in_rdy | output | 1 | Ready to accept input |
| irq | output | 1 | Level interrupt request |
| irq_src | output | 1 | Reported source: 1 input, 0 output |
| irq_ack | input | 1 | Acknowledge pulse for the reported source |

## Verification
Two pairs of events can fall on the same clock edge. The first is an input transfer completing together with an output transfer. The bench provokes it by releasing both strobes on one edge, then judges it by the order in which irq_src reports the two sources across two acknowledges. The second is a CPU data write landing on the same edge as an output strobe rise. The bench judges this one by checking that out_rdy stays high with the new byte on pd_out while the output interrupt is still raised.

// File: rtl/hsp_pkg.sv
// Shared types for the bidirectional handshake port.
package hsp_pkg;
    typedef enum logic {SRC_OUT = 1'b0, SRC_IN = 1'b1} irq_src_e;
endpackage

// File: rtl/hsp_bus_decode.sv
// CPU bus decode: qualifies data/control accesses, detects their first
// cycle, holds the interrupt enable bits and muxes read data.
// Assumes all CPU inputs are synchronous to clk.
module hsp_bus_decode #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic          cpu_ce,
    input  logic          cpu_dsel,
    input  logic          cpu_iorq,
    input  logic [1:0]    ctl_wbits,
    input  logic [DW-1:0] in_data,
    output logic          data_wr_lead,
    output logic          data_rd_lead,
    output logic          en_out,
    output logic          en_in,
    output logic [DW-1:0] cpu_rdata
);
    logic sel_any, d_rd, d_wr, c_rd, c_wr;
    logic d_rd_q, d_wr_q, c_wr_q;

    assign sel_any = cpu_ce & cpu_iorq;
    assign d_rd    = sel_any & cpu_rd &  cpu_dsel;
    assign d_wr    = sel_any & cpu_wr &  cpu_dsel;
    assign c_rd    = sel_any & cpu_rd & ~cpu_dsel;
    assign c_wr    = sel_any & cpu_wr & ~cpu_dsel;

    assign data_wr_lead = d_wr & ~d_wr_q & mode;
    assign data_rd_lead = d_rd & ~d_rd_q & mode;

    // Remember last-cycle access terms for leading-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_rd_q <= 1'b0;
            d_wr_q <= 1'b0;
            c_wr_q <= 1'b0;
        end else begin
            d_rd_q <= d_rd;
            d_wr_q <= d_wr;
            c_wr_q <= c_wr;
        end
    end

    // Interrupt enable bits, written once per control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_out <= 1'b0;
            en_in  <= 1'b0;
        end else if (c_wr && !c_wr_q) begin
            en_out <= ctl_wbits[0];
            en_in  <= ctl_wbits[1];
        end
    end

    // Read data mux: input register only for a fully qualified data read.
    always_comb begin
        cpu_rdata = '0;
        if (d_rd)
            cpu_rdata = in_data;
        else if (c_rd)
            cpu_rdata = {{(DW-2){1'b0}}, en_in, en_out};
    end

    a_r8_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && !c_wr_q) |=> (en_out == $past(ctl_wbits[0]) && en_in == $past(ctl_wbits[1])));
endmodule

// File: rtl/hsp_out_path.sv
// Output direction: output latch, output-ready state and pin drive control.
// Assumes out_stb_n is synchronous to clk. Pins are driven only while the
// peripheral holds the strobe low; its rising edge completes the transfer.
module hsp_out_path #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode,
    input  logic          wr_lead,
    input  logic [DW-1:0] wdata,
    input  logic          out_stb_n,
    output logic          out_rdy,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe,
    output logic          out_done
);
    logic          stb_q, stb_rise, full;
    logic [DW-1:0] latch_q;

    assign stb_rise = out_stb_n & ~stb_q & mode;
    assign out_done = stb_rise & full;
    assign out_rdy  = full & mode;
    assign pd_oe    = mode & ~out_stb_n;
    assign pd_out   = latch_q;

    // Track previous strobe level for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b1;
        else        stb_q <= out_stb_n;
    end

    // Output latch loads on every qualified data write.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q <= '0;
        else if (wr_lead) latch_q <= wdata;
    end

    // Full flag: set by a write, cleared by a completing strobe; write wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        full <= 1'b0;
        else if (wr_lead)  full <= 1'b1;
        else if (stb_rise) full <= 1'b0;
    end

    a_r2_write_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lead |=> full);
    a_r4_rise_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_rise && full && !wr_lead) |=> !full);
    a_r10_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> (!pd_oe && !out_rdy));
endmodule

// File: rtl/hsp_in_path.sv
// Input direction: input register, acceptance of a strobe and the ready
// line with its post-read low gap of GAP cycles.
// Assumes in_stb_n is synchronous to clk.
module hsp_in_path #(
    parameter int DW  = 8,
    parameter int GAP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode,
    input  logic          rd_lead,
    input  logic          in_stb_n,
    input  logic [DW-1:0] pd_in,
    output logic          in_rdy,
    output logic [DW-1:0] in_data,
    output logic          in_done
);
    localparam int GW = (GAP < 1) ? 1 : $clog2(GAP + 1);

    logic          stb_q, fall, rise, accept, full, loading;
    logic [GW-1:0] gap_q;
    logic [DW-1:0] reg_q;

    assign fall    = ~in_stb_n &  stb_q & mode;
    assign rise    =  in_stb_n & ~stb_q & mode;
    assign in_rdy  = mode & ~full & (gap_q == '0);
    assign loading = ~in_stb_n & mode & (accept | (fall & in_rdy));
    assign in_done = rise & accept;
    assign in_data = reg_q;

    // Track previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b1;
        else        stb_q <= in_stb_n;
    end

    // A strobe is accepted only if ready was high when it fell.
    always_ff @(posedge clk) begin
        if (!rst_n)    accept <= 1'b0;
        else if (fall) accept <= in_rdy;
        else if (rise) accept <= 1'b0;
    end

    // Input register follows the pins during an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       reg_q <= '0;
        else if (loading) reg_q <= pd_in;
    end

    // Full flag: set on completion, cleared by a CPU read; completion wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       full <= 1'b0;
        else if (in_done) full <= 1'b1;
        else if (rd_lead) full <= 1'b0;
    end

    // Ready low gap counter started by every data read.
    always_ff @(posedge clk) begin
        if (!rst_n)             gap_q <= '0;
        else if (rd_lead)       gap_q <= GW'(GAP);
        else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
    end

    a_r7_read_drops_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lead |=> !in_rdy);
    a_r5_reject_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !accept && !rd_lead) |=> $stable(full));
    a_r5_done_drops_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        in_done |=> !in_rdy);
endmodule

// File: rtl/hsp_irq.sv
// Interrupt pending flags, enable masking and source priority (input first).
// Acknowledge clears only the source currently reported.
module hsp_irq
    import hsp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_done,
    input  logic out_done,
    input  logic en_in,
    input  logic en_out,
    input  logic irq_ack,
    output logic irq,
    output logic irq_src
);
    logic     pend_in, pend_out, act_in, act_out, ack_in, ack_out;
    irq_src_e src;

    assign act_in  = pend_in  & en_in;
    assign act_out = pend_out & en_out;
    assign irq     = act_in | act_out;
    assign src     = act_in ? SRC_IN : SRC_OUT;
    assign irq_src = (src == SRC_IN);
    assign ack_in  = irq_ack & act_in;
    assign ack_out = irq_ack & ~act_in & act_out;

    // Pending flags: a new completion outranks an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_in  <= 1'b0;
            pend_out <= 1'b0;
        end else begin
            if (in_done)      pend_in  <= 1'b1;
            else if (ack_in)  pend_in  <= 1'b0;
            if (out_done)     pend_out <= 1'b1;
            else if (ack_out) pend_out <= 1'b0;
        end
    end

    a_r9_ack_keeps_out: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && act_in && act_out) |=> pend_out);
    a_r9_ack_clears_in: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && !in_done) |=> !pend_in);
    a_r8_done_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> pend_out);
endmodule

// File: rtl/bidir_hs_port.sv
// Top of the bidirectional handshake parallel port. Connects the CPU bus
// decode, both transfer directions and interrupt generation.
// Assumes a single clock domain for CPU and peripheral signals.
module bidir_hs_port #(
    parameter int DW      = 8,
    parameter int RDY_GAP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_bidir,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic          cpu_ce,
    input  logic          cpu_dsel,
    input  logic          cpu_iorq,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic [DW-1:0] pd_in,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe,
    input  logic          out_stb_n,
    output logic          out_rdy,
    input  logic          in_stb_n,
    output logic          in_rdy,
    output logic          irq,
    output logic          irq_src,
    input  logic          irq_ack
);
    logic          wr_lead, rd_lead, en_out, en_in, out_done, in_done;
    logic [DW-1:0] in_data;

    hsp_bus_decode #(.DW(DW)) u_dec (
        .clk(clk), .rst_n(rst_n), .mode(mode_bidir),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_ce(cpu_ce),
        .cpu_dsel(cpu_dsel), .cpu_iorq(cpu_iorq),
        .ctl_wbits(cpu_wdata[1:0]), .in_data(in_data),
        .data_wr_lead(wr_lead), .data_rd_lead(rd_lead),
        .en_out(en_out), .en_in(en_in), .cpu_rdata(cpu_rdata)
    );

    hsp_out_path #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .mode(mode_bidir),
        .wr_lead(wr_lead), .wdata(cpu_wdata), .out_stb_n(out_stb_n),
        .out_rdy(out_rdy), .pd_out(pd_out), .pd_oe(pd_oe),
        .out_done(out_done)
    );

    hsp_in_path #(.DW(DW), .GAP(RDY_GAP)) u_in (
        .clk(clk), .rst_n(rst_n), .mode(mode_bidir),
        .rd_lead(rd_lead), .in_stb_n(in_stb_n), .pd_in(pd_in),
        .in_rdy(in_rdy), .in_data(in_data), .in_done(in_done)
    );

    hsp_irq u_irq (
        .clk(clk), .rst_n(rst_n), .in_done(in_done), .out_done(out_done),
        .en_in(en_in), .en_out(en_out), .irq_ack(irq_ack),
        .irq(irq), .irq_src(irq_src)
    );

    a_r3_pins_released: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb_n |-> !pd_oe);
endmodule

// File: tb/test_bidir_hs_port.sv
module test_bidir_hs_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_bidir = 1'b1;
    logic       cpu_rd = 0, cpu_wr = 0, cpu_ce = 0, cpu_dsel = 0, cpu_iorq = 0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic [7:0] pd_in = 8'h00;
    logic [7:0] pd_out;
    logic       pd_oe, out_rdy, in_rdy, irq, irq_src;
    logic       out_stb_n = 1'b1, in_stb_n = 1'b1, irq_ack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // {is_read, ce, dsel, iorq, expect_effect}
    localparam logic [4:0] VEC [16] = '{
        5'b1_111_1, 5'b1_110_0, 5'b1_101_0, 5'b1_100_0,
        5'b1_011_0, 5'b1_010_0, 5'b1_001_0, 5'b1_000_0,
        5'b0_111_1, 5'b0_110_0, 5'b0_101_0, 5'b0_100_0,
        5'b0_011_0, 5'b0_010_0, 5'b0_001_0, 5'b0_000_0
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    bidir_hs_port i_bidir_hs_port (
        .clk(clk), .rst_n(rst_n), .mode_bidir(mode_bidir),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_ce(cpu_ce),
        .cpu_dsel(cpu_dsel), .cpu_iorq(cpu_iorq), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
        .out_stb_n(out_stb_n), .out_rdy(out_rdy), .in_stb_n(in_stb_n),
        .in_rdy(in_rdy), .irq(irq), .irq_src(irq_src), .irq_ack(irq_ack)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic nedge();
        @(negedge clk);
    endtask

    task automatic bus_idle();
        cpu_rd = 0; cpu_wr = 0; cpu_ce = 0; cpu_dsel = 0; cpu_iorq = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; bus_idle(); out_stb_n = 1; in_stb_n = 1; irq_ack = 0;
        repeat (3) nedge();
        rst_n = 1;
        nedge();
    endtask

    // One-cycle qualified access; leaves the bus idle at the next negedge.
    task automatic access(input logic wr, input logic dsel, input logic [7:0] d);
        cpu_wr = wr; cpu_rd = ~wr; cpu_ce = 1; cpu_iorq = 1; cpu_dsel = dsel;
        cpu_wdata = d;
        nedge();
        bus_idle();
    endtask

    task automatic ack_pulse();
        irq_ack = 1; nedge(); irq_ack = 0;
    endtask

    task automatic in_xfer(input logic [7:0] d);
        pd_in = d; in_stb_n = 0; nedge(); in_stb_n = 1; nedge();
    endtask

    initial begin
        do_reset();
        // R1 reset state
        check("R1 out_rdy", out_rdy, 0);
        check("R1 in_rdy", in_rdy, 1);
        check("R1 pd_oe", pd_oe, 0);
        check("R1 irq", irq, 0);
        cpu_rd = 1; cpu_ce = 1; cpu_iorq = 1; cpu_dsel = 0; #1;
        check("R1 enables", cpu_rdata, 8'h00);
        nedge(); bus_idle();
        nedge();

        // Preload input register
        in_xfer(8'h5A);
        check("R5 in_rdy after strobe", in_rdy, 0);

        // Vector table: qualification of reads and writes
        for (int i = 0; i < 16; i++) begin
            cpu_rd = VEC[i][4]; cpu_wr = ~VEC[i][4];
            cpu_ce = VEC[i][3]; cpu_dsel = VEC[i][2]; cpu_iorq = VEC[i][1];
            cpu_wdata = 8'hC0 | 8'(i);
            #1;
            if (VEC[i][4]) begin
                check("R6 rdata qualify", cpu_rdata, VEC[i][0] ? 8'h5A : 8'h00);
                nedge(); bus_idle();
            end else begin
                nedge(); bus_idle(); #1;
                check("R2 write qualify", out_rdy, VEC[i][0]);
                if (VEC[i][0]) begin
                    out_stb_n = 0; #1;
                    check("R3 pd_oe on strobe", pd_oe, 1);
                    check("R3 pd_out", pd_out, 8'hC0 | 8'(i));
                    nedge(); out_stb_n = 1; #1;
                    check("R3 pd_oe released", pd_oe, 0);
                    nedge();
                    check("R4 out_rdy drop", out_rdy, 0);
                end
            end
            nedge();
        end

        // Directed tests
        do_reset();
        access(1, 0, 8'h03);
        cpu_rd = 1; cpu_ce = 1; cpu_iorq = 1; cpu_dsel = 0; #1;
        check("R8 enables read", cpu_rdata, 8'h03);
        nedge(); bus_idle();

        // R7: read while ready already high
        check("R7 ready before", in_rdy, 1);
        access(0, 1, 8'h00);
        check("R7 gap cycle 1", in_rdy, 0);
        nedge();
        check("R7 gap cycle 2", in_rdy, 0);
        nedge();
        check("R7 ready back", in_rdy, 1);

        // R5: accepted transfer, then rejected strobe while ready low
        in_xfer(8'h11);
        check("R5 in_rdy low", in_rdy, 0);
        check("R8 irq input", irq, 1);
        check("R8 irq_src input", irq_src, 1);
        ack_pulse();
        check("R9 ack clears", irq, 0);
        in_xfer(8'h22);
        check("R5 rejected no irq", irq, 0);
        check("R5 rejected rdy", in_rdy, 0);
        cpu_rd = 1; cpu_ce = 1; cpu_iorq = 1; cpu_dsel = 1; #1;
        check("R5 data kept", cpu_rdata, 8'h11);
        nedge(); bus_idle();
        repeat (3) nedge();
        check("R7 ready after full read", in_rdy, 1);

        // R9: both directions complete on the same edge
        access(1, 1, 8'h77);
        check("R2 out_rdy", out_rdy, 1);
        pd_in = 8'h33; out_stb_n = 0; in_stb_n = 0;
        nedge();
        out_stb_n = 1; in_stb_n = 1;
        nedge();
        check("R9 irq both", irq, 1);
        check("R9 input first", irq_src, 1);
        check("R9 in_rdy", in_rdy, 0);
        check("R4 out_rdy", out_rdy, 0);
        ack_pulse();
        check("R9 output next irq", irq, 1);
        check("R9 output next src", irq_src, 0);
        ack_pulse();
        check("R9 all cleared", irq, 0);

        // R11: write collides with completing output strobe
        access(1, 1, 8'h44);
        out_stb_n = 0;
        nedge();
        out_stb_n = 1;
        access(1, 1, 8'h55);
        check("R11 out_rdy kept", out_rdy, 1);
        check("R11 new data", pd_out, 8'h55);
        check("R11 irq", irq, 1);
        check("R11 irq_src", irq_src, 0);
        ack_pulse();

        // R10: mode low
        mode_bidir = 0; #1;
        check("R10 out_rdy", out_rdy, 0);
        check("R10 in_rdy", in_rdy, 0);
        out_stb_n = 0; #1;
        check("R10 pd_oe", pd_oe, 0);
        access(1, 1, 8'h99);
        out_stb_n = 1;
        nedge();
        mode_bidir = 1; #1;
        check("R10 latch kept", pd_out, 8'h55);
        check("R10 ready kept", out_rdy, 1);
        check("R10 no irq", irq, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule